// File: doc/BRIEF.md
# SD Host Event Status and Interrupt Unit

This unit holds the sticky event word of an SD/MMC host controller and turns it into a single interrupt line. The command and data engines send one-cycle pulses for nine events: command sent, response timeout, response CRC good, response CRC bad, data timeout, data CRC bad, data end, FIFO overrun and FIFO underrun. A tenth event, card change, comes from the unit's own synchronizer on the card-detect pin. The live card-detect level is also shown in the status word. Software reads the word and acknowledges events by writing ones to a separate clear register.

A mask register selects which sticky bits drive the interrupt. A data-control register lets software arm a data transfer. The transfer start is released only when the command-sent event arrives. Writing the software-reset bit of the command register starts a reset sequence of fixed length. The sequence wipes every register. Because there is no done flag, the data-timeout register reads all ones while the sequence runs and zero once it has finished.

Top module: `sdhc_event_unit`

## Requirements
- R1: A pulse on `engEvt[i]` sets sticky status bit i, which then holds until it is cleared. The bit positions are: 0 command sent, 1 response timeout, 2 response CRC good, 3 response CRC bad, 4 data timeout, 5 data CRC bad, 6 data end, 7 FIFO overrun, 8 FIFO underrun. Status is read at address 0.
- R2: A write to the clear register (address 1) clears exactly those sticky bits whose positions are one in the written word. Every other bit keeps its value.
- R3: When an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R4: Status bit 10 is the card-detect level after a two-flop synchronizer. It reads 0 when a card is present and 1 when no card is present. A change on `cardDetN` is visible two cycles later.
- R5: Status bit 9 (card change) becomes sticky one cycle after the synchronized level changes, for both card insertion and card removal.
- R6: `irq` is the OR over bits 0 to 9 of (status AND mask), registered, so it trails the status word by one cycle.
- R7: The mask register (address 2, bits 9:0) resets to zero and reads back what was written.
- R8: Writing bit 10 of the command register (address 3) starts a software reset lasting RST_CYCLES cycles. After the reset the status, mask, data-timeout and data-control registers and `irq` are all zero.
- R9: The data-timeout register (address 4) reads all ones while the software reset runs. It reads zero in the first cycle after the reset finishes, and otherwise reads back what was written.
- R10: Writing 1 to bit 0 of the data-control register (address 5) arms a transfer. `xferStart` pulses for one cycle, one cycle after the next command-sent event, and this disarms the register. Without arming, command sent gives no pulse, and other events leave the arm bit set.
- R11: While the software reset runs, register writes and engine events have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for read and write |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Read data for `regAddr` (combinational) |
| engEvt | input | 9 | Event pulses from the command and data engines |
| cardDetN | input | 1 | Asynchronous card-detect pin, low when a card is present |
| irq | output | 1 | Interrupt request |
| xferStart | output | 1 | Pulse that releases the armed data transfer |

## Verification
The collision that matters here is an engine event and a software clear of the same status bit in the same cycle. The bench provokes it by driving a response-CRC-good pulse together with a clear word. That word covers the same bit and also a second bit that is already set. The result is judged on the status word: the colliding bit must still read one and the other bit must read zero. A second overlap is a register write and an event burst arriving during the software-reset window. The bench judges it by reading the status and mask words after the window closes and finding them at their reset values.

// File: rtl/sdhc_evt_pkg.sv
package sdhc_evt_pkg;

  localparam int ENG_EVT_N   = 9;   // events from command/data engines
  localparam int STICKY_N    = 10;  // engine events + card change
  localparam int CMD_SENT_IX = 0;
  localparam int CARD_CHG_IX = 9;
  localparam int CARD_LVL_IX = 10;
  localparam int SRST_IX     = 10;  // reset bit in the command register
  localparam int ADDR_W      = 3;

  localparam logic [ADDR_W-1:0] ADR_STAT = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_CLR  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_MASK = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CMD  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_DTO  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_DCTL = 3'd5;

  // strobes from control to datapath
  typedef struct packed {
    logic clrStb;
    logic maskStb;
    logic dtoStb;
    logic armStb;
    logic wipe;
  } ctlStb_t;

endpackage

// File: rtl/sdhc_evt_ctrl.sv
module sdhc_evt_ctrl
  import sdhc_evt_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              srstBit,
  output ctlStb_t           stb,
  output logic              rstBusy
);

  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES);

  logic [CNT_W-1:0] rstCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstCnt <= '0;
    end else if (rstCnt != '0) begin
      rstCnt <= rstCnt - 1'b1;
    end else if (regWr && (regAddr == ADR_CMD) && srstBit) begin
      rstCnt <= CNT_LOAD;
    end
  end

  assign rstBusy = (rstCnt != '0);

  always_comb begin
    stb         = '0;
    stb.wipe    = rstBusy;
    stb.clrStb  = regWr && !rstBusy && (regAddr == ADR_CLR);
    stb.maskStb = regWr && !rstBusy && (regAddr == ADR_MASK);
    stb.dtoStb  = regWr && !rstBusy && (regAddr == ADR_DTO);
    stb.armStb  = regWr && !rstBusy && (regAddr == ADR_DCTL);
  end

endmodule

// File: rtl/sdhc_evt_dp.sv
module sdhc_evt_dp
  import sdhc_evt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DTO_W  = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStb_t              stb,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [ADDR_W-1:0]    rdAddr,
  input  logic [ENG_EVT_N-1:0] engEvt,
  input  logic                 cardDetN,
  output logic [DATA_W-1:0]    rdData,
  output logic                 irq,
  output logic                 xferStart,
  output logic [STICKY_N-1:0]  stickyQ,
  output logic [STICKY_N-1:0]  maskQ
);

  localparam int SYNC_N = 3;

  logic [SYNC_N-1:0]   cardSync;
  logic                cardLvl;
  logic                cardChg;
  logic [STICKY_N-1:0] evtVec;
  logic [DTO_W-1:0]    dtoQ;
  logic                armedQ;

  // two sync flops plus one history flop for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cardSync <= '1;
    else       cardSync <= {cardSync[SYNC_N-2:0], cardDetN};
  end

  assign cardLvl = cardSync[1];
  assign cardChg = cardSync[1] ^ cardSync[2];
  assign evtVec  = {cardChg, engEvt} & {STICKY_N{!stb.wipe}};

  for (genvar i = 0; i < STICKY_N; i++) begin : g_sticky
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                        stickyQ[i] <= 1'b0;
      else if (stb.wipe)                stickyQ[i] <= 1'b0;
      else if (evtVec[i])               stickyQ[i] <= 1'b1;
      else if (stb.clrStb && wrData[i]) stickyQ[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ     <= '0;
      dtoQ      <= '0;
      armedQ    <= 1'b0;
      irq       <= 1'b0;
      xferStart <= 1'b0;
    end else if (stb.wipe) begin
      maskQ     <= '0;
      dtoQ      <= '0;
      armedQ    <= 1'b0;
      irq       <= 1'b0;
      xferStart <= 1'b0;
    end else begin
      if (stb.maskStb) maskQ <= wrData[STICKY_N-1:0];
      if (stb.dtoStb)  dtoQ  <= wrData[DTO_W-1:0];
      if (armedQ && evtVec[CMD_SENT_IX]) armedQ <= 1'b0;
      else if (stb.armStb)               armedQ <= wrData[0];
      xferStart <= armedQ && evtVec[CMD_SENT_IX];
      irq       <= |(stickyQ & maskQ);
    end
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADR_STAT: rdData[CARD_LVL_IX:0] = {cardLvl, stickyQ};
      ADR_MASK: rdData[STICKY_N-1:0]  = maskQ;
      ADR_DTO:  rdData[DTO_W-1:0]     = stb.wipe ? '1 : dtoQ;
      ADR_DCTL: rdData[0]             = armedQ;
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/sdhc_event_unit.sv
module sdhc_event_unit
  import sdhc_evt_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int DTO_W      = 32,
  parameter int RST_CYCLES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWr,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  input  logic [ENG_EVT_N-1:0] engEvt,
  input  logic                 cardDetN,
  output logic                 irq,
  output logic                 xferStart
);

  ctlStb_t             ctlStb;
  logic                rstBusy;
  logic [STICKY_N-1:0] stickyQ;
  logic [STICKY_N-1:0] maskQ;

  sdhc_evt_ctrl #(.RST_CYCLES(RST_CYCLES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWr   (regWr),
    .regAddr (regAddr),
    .srstBit (regWrData[SRST_IX]),
    .stb     (ctlStb),
    .rstBusy (rstBusy)
  );

  sdhc_evt_dp #(.DATA_W(DATA_W), .DTO_W(DTO_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (ctlStb),
    .wrData    (regWrData),
    .rdAddr    (regAddr),
    .engEvt    (engEvt),
    .cardDetN  (cardDetN),
    .rdData    (regRdData),
    .irq       (irq),
    .xferStart (xferStart),
    .stickyQ   (stickyQ),
    .maskQ     (maskQ)
  );

endmodule

// File: rtl/sdhc_evt_chk.sv
module sdhc_evt_chk
  import sdhc_evt_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 busy,
  input logic [STICKY_N-1:0]  sticky,
  input logic [STICKY_N-1:0]  mask,
  input logic [ENG_EVT_N-1:0] engEvt,
  input logic                 clrStb,
  input logic                 irq,
  input logic                 xferStart
);

  p_sticky_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !clrStb) |=> (($past(sticky) & ~sticky) == '0));

  p_set_wins_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && engEvt != '0) |=>
      ((sticky[ENG_EVT_N-1:0] & $past(engEvt)) == $past(engEvt)));

  p_irq_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (mask == '0) |=> !irq);

  p_wipe_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (sticky == '0 && mask == '0 && !irq));

  p_start_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |=> !xferStart);

  p_start_cause_r10: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |-> $past(engEvt[CMD_SENT_IX]));

endmodule

bind sdhc_event_unit sdhc_evt_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (rstBusy),
  .sticky    (stickyQ),
  .mask      (maskQ),
  .engEvt    (engEvt),
  .clrStb    (ctlStb.clrStb),
  .irq       (irq),
  .xferStart (xferStart)
);

// File: tb/sim_sdhc_event_unit.sv
`timescale 1ns/1ps
module sim_sdhc_event_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWrData = 32'd0;
  logic [31:0] regRdData;
  logic [8:0]  engEvt = 9'd0;
  logic        cardDetN = 1'b1;
  logic        irq;
  logic        xferStart;

  always #4 clk = ~clk;

  sdhc_event_unit u0 (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .engEvt(engEvt),
    .cardDetN(cardDetN), .irq(irq), .xferStart(xferStart)
  );

  localparam int K_RD = 0, K_IRQ = 1, K_XFR = 2;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // monitor: pops expected items and compares them with the outputs
  initial begin
    forever begin
      item_t it;
      logic [31:0] act;
      wait (q.size() != 0);
      #0.2;
      it = q.pop_front();
      case (it.kind)
        K_RD:    act = regRdData;
        K_IRQ:   act = {31'd0, irq};
        default: act = {31'd0, xferStart};
      endcase
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  // driver tasks: called in the low clock phase, they return at a negedge
  task automatic chk(input int kind, input logic [2:0] a,
                     input logic [31:0] e, input string t);
    regAddr = a;
    q.push_back('{kind: kind, exp: e, tag: t});
    #0.5;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0; regWrData = 32'd0;
  endtask

  task automatic evt(input logic [8:0] b);
    engEvt = b;
    @(negedge clk);
    engEvt = 9'd0;
  endtask

  task automatic evtWr(input logic [8:0] b, input logic [2:0] a,
                       input logic [31:0] d);
    engEvt = b; regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    engEvt = 9'd0; regWr = 1'b0; regWrData = 32'd0;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(3);
    // reset state
    chk(K_RD, 3'd0, 32'h400, "R4 reset status, no card");
    chk(K_RD, 3'd2, 32'h000, "R7 reset mask");
    chk(K_IRQ, 3'd0, 32'd0, "R6 reset irq");
    chk(K_XFR, 3'd0, 32'd0, "R10 reset xferStart");

    // R1 sticky set
    evt(9'h0A5);
    chk(K_RD, 3'd0, 32'h4A5, "R1 events set sticky bits");
    cyc(3);
    chk(K_RD, 3'd0, 32'h4A5, "R1 sticky bits hold");

    // R2 write-one-to-clear
    wr(3'd1, 32'h0A1);
    chk(K_RD, 3'd0, 32'h404, "R2 clear only ones");
    chk(K_RD, 3'd1, 32'h000, "R2 clear register reads zero");

    // R3 set wins over clear
    evt(9'h008);
    chk(K_RD, 3'd0, 32'h40C, "R3 setup");
    evtWr(9'h004, 3'd1, 32'h00C);
    chk(K_RD, 3'd0, 32'h404, "R3 set wins, other bit cleared");

    // R7 / R6 mask and interrupt latency
    wr(3'd2, 32'h001);
    chk(K_RD, 3'd2, 32'h001, "R7 mask readback");
    cyc(1);
    chk(K_IRQ, 3'd0, 32'd0, "R6 unmasked bit gives no irq");
    evt(9'h001);
    chk(K_IRQ, 3'd0, 32'd0, "R6 irq one cycle after status");
    cyc(1);
    chk(K_IRQ, 3'd0, 32'd1, "R6 irq asserted");
    wr(3'd1, 32'h001);
    chk(K_IRQ, 3'd0, 32'd1, "R6 irq trails clear");
    cyc(1);
    chk(K_IRQ, 3'd0, 32'd0, "R6 irq drops after clear");

    // R4 / R5 card detect level and change on insertion
    cardDetN = 1'b0;
    cyc(1);
    chk(K_RD, 3'd0, 32'h404, "R4 level not yet through sync");
    cyc(1);
    chk(K_RD, 3'd0, 32'h004, "R4 card present after two cycles");
    cyc(1);
    chk(K_RD, 3'd0, 32'h204, "R5 change on insertion");
    wr(3'd1, 32'h204);
    chk(K_RD, 3'd0, 32'h000, "R2 clear change and crc bits");
    cardDetN = 1'b1;
    cyc(3);
    chk(K_RD, 3'd0, 32'h600, "R5 change on removal");
    wr(3'd1, 32'h200);
    chk(K_RD, 3'd0, 32'h400, "R5 change cleared");

    // R10 armed transfer waits for command sent
    evt(9'h001);
    chk(K_XFR, 3'd0, 32'd0, "R10 no pulse when not armed");
    wr(3'd5, 32'h1);
    chk(K_RD, 3'd5, 32'h1, "R10 armed readback");
    evt(9'h002);
    chk(K_XFR, 3'd0, 32'd0, "R10 other event gives no pulse");
    chk(K_RD, 3'd5, 32'h1, "R10 still armed");
    evt(9'h001);
    chk(K_XFR, 3'd0, 32'd1, "R10 pulse after command sent");
    chk(K_RD, 3'd5, 32'h0, "R10 disarmed");
    cyc(1);
    chk(K_XFR, 3'd0, 32'd0, "R10 single pulse");

    // R8 / R9 / R11 software reset
    wr(3'd2, 32'h3FF);
    wr(3'd4, 32'h1234);
    chk(K_RD, 3'd4, 32'h1234, "R9 dto readback");
    wr(3'd5, 32'h1);
    evt(9'h1FF);
    cyc(1);
    chk(K_IRQ, 3'd0, 32'd1, "R8 setup irq high");
    wr(3'd3, 32'h400);
    chk(K_RD, 3'd4, 32'hFFFF_FFFF, "R9 dto all ones at reset start");
    evtWr(9'h1FF, 3'd2, 32'h0FF);
    cyc(2);
    chk(K_RD, 3'd4, 32'hFFFF_FFFF, "R9 dto all ones in last reset cycle");
    cyc(1);
    chk(K_RD, 3'd4, 32'h0, "R9 dto zero after reset");
    chk(K_RD, 3'd0, 32'h400, "R11 events ignored, R8 status wiped");
    chk(K_RD, 3'd2, 32'h000, "R11 mask write ignored, R8 mask wiped");
    chk(K_RD, 3'd5, 32'h0, "R8 data control wiped");
    chk(K_IRQ, 3'd0, 32'd0, "R8 irq wiped");

    // back to normal operation
    evt(9'h100);
    chk(K_RD, 3'd0, 32'h500, "R1 events after reset");
    wr(3'd2, 32'h100);
    cyc(1);
    chk(K_IRQ, 3'd0, 32'd1, "R6 irq after reset");

    cyc(2);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule